// File: doc/BRIEF.md
# Memory-Mapped I/O Hole Address Remapper

This block sits on the request port of a memory system and removes the memory-mapped I/O hole from the physical address space seen by the memory behind it. The hole spans from 3.5 GB up to, but not including, 4 GB. A request that lands inside the hole is never forwarded. Instead, the block answers it by itself with a read-done or write-done strobe that carries the original address. A request above the hole is moved down by the hole size (0.5 GB), so that the memory behind the block sees a dense address space. A request below the hole passes through unchanged.

Remapping runs only while `remap_en_i` is high. While it is low, every legal request is forwarded with its address untouched. Prefetch and flush operations belong to the internal side of the memory system. When one arrives on this external port, the block flags it as illegal and discards it. Every output is registered, so each response appears in the cycle after the request is accepted. One-cycle event pulses report each dropped request and each remapped request, so that external counters can tally them.

Top module: `mmio_hole_remap`

## Requirements
- R1: While `rst_ni` is low, every strobe output (`fwd_valid_o`, `rd_done_o`, `wr_done_o`, `drop_pulse_o`, `remap_pulse_o`, `illegal_o`) is 0.
- R2: With remapping on, a legal request whose address is below 0xE000_0000 produces `fwd_valid_o` = 1 in the next cycle. That cycle carries the same address, write flag and type.
- R3: With remapping on, a legal read (`req_write_i` = 0) whose address is in [0xE000_0000, 0x1_0000_0000) is not forwarded. In the next cycle it produces `rd_done_o` = 1 and `wr_done_o` = 0, with `done_addr_o` equal to the original address.
- R4: With remapping on, a legal write (`req_write_i` = 1) in the hole is not forwarded. In the next cycle it produces `wr_done_o` = 1 and `rd_done_o` = 0, with `done_addr_o` equal to the original address.
- R5: With remapping on, a legal request at or above 0x1_0000_0000 is forwarded in the next cycle with the address reduced by 0x2000_0000, and `remap_pulse_o` is 1 in that same cycle.
- R6: `drop_pulse_o` is 1 for exactly the one cycle in which a hole completion is returned, and is 0 at all other times.
- R7: Type encoding: 0 = data, 1 = prefetch, 2 = flush, 3 = sync. A prefetch or flush request raises `illegal_o` in the next cycle. That cycle shows no forward, no completion, no drop pulse and no remap pulse.
- R8: With `remap_en_i` = 0, every legal request is forwarded with its address unchanged, including addresses in or above the hole, and neither event pulse fires.
- R9: The boundary addresses 0xDFFF_FFFF (forwarded as is), 0xE000_0000 and 0xFFFF_FFFF (completed in place), and 0x1_0000_0000 (forwarded as 0xE000_0000) are classified exactly.
- R10: A cycle with `req_valid_i` = 0 yields no forward, completion, event or illegal strobe in the following cycle.
- R11: A sync-type request (type 3) is treated as a legal request and is routed by address like a data request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| remap_en_i | input | 1 | Enables hole removal |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_type_i | input | 2 | 0 data, 1 prefetch, 2 flush, 3 sync |
| req_addr_i | input | 64 | Request physical address |
| fwd_valid_o | output | 1 | Forwarded request valid |
| fwd_write_o | output | 1 | Forwarded write flag |
| fwd_type_o | output | 2 | Forwarded type |
| fwd_addr_o | output | 64 | Remapped address |
| rd_done_o | output | 1 | Immediate read completion for a hole access |
| wr_done_o | output | 1 | Immediate write completion for a hole access |
| done_addr_o | output | 64 | Original address of the completed request |
| drop_pulse_o | output | 1 | One-cycle pulse per dropped hole request |
| remap_pulse_o | output | 1 | One-cycle pulse per shifted request |
| illegal_o | output | 1 | Prefetch or flush seen on this port |

## Verification
Directed requests sit on each side of both hole edges. These separate an off-by-one compare at the lower bound from one at the upper bound, and show whether the shift is applied at exactly 4 GB. The same addresses are repeated with remapping off, which shows that the enable controls both the drop and the shift. Prefetch, flush and sync types are sent into the hole and above it, which shows that legality is decided before the address is routed. Random traffic follows, biased toward low memory, the hole, just above 4 GB and the far top of the 64-bit space. Read and write, all four types, enable on and off, and idle cycles are mixed at random. This exercises the path choice and the subtraction across the whole range.

// File: rtl/mmio_hole_pkg.sv
package mmio_hole_pkg;
  typedef enum logic [1:0] {
    TXN_DATA     = 2'd0,
    TXN_PREFETCH = 2'd1,
    TXN_FLUSH    = 2'd2,
    TXN_SYNC     = 2'd3
  } txn_e;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_HOLE = 2'd1,
    REG_HIGH = 2'd2
  } region_e;

  function automatic logic txn_is_legal(logic [1:0] t);
    return (t != TXN_PREFETCH) && (t != TXN_FLUSH);
  endfunction
endpackage

// File: rtl/hole_region_decode.sv
module hole_region_decode
  import mmio_hole_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 64,
  parameter logic [ADDR_W-1:0]    HOLE_BASE = 64'h0000_0000_E000_0000,
  parameter logic [ADDR_W-1:0]    HOLE_END  = 64'h0000_0001_0000_0000
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  always_comb begin
    region_o = REG_LOW;
    if (en_i) begin
      if (addr_i >= HOLE_END)       region_o = REG_HIGH;
      else if (addr_i >= HOLE_BASE) region_o = REG_HOLE;
    end
  end
endmodule

// File: rtl/hole_addr_shift.sv
module hole_addr_shift
  import mmio_hole_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] HOLE_SIZE = 64'h0000_0000_2000_0000
) (
  input  region_e           region_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = (region_i == REG_HIGH) ? (addr_i - HOLE_SIZE) : addr_i;
endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_valid_d,
  input  logic              fwd_write_d,
  input  logic [1:0]        fwd_type_d,
  input  logic [ADDR_W-1:0] fwd_addr_d,
  input  logic              rd_done_d,
  input  logic              wr_done_d,
  input  logic [ADDR_W-1:0] done_addr_d,
  input  logic              drop_d,
  input  logic              remap_d,
  input  logic              illegal_d,
  output logic              fwd_valid_q,
  output logic              fwd_write_q,
  output logic [1:0]        fwd_type_q,
  output logic [ADDR_W-1:0] fwd_addr_q,
  output logic              rd_done_q,
  output logic              wr_done_q,
  output logic [ADDR_W-1:0] done_addr_q,
  output logic              drop_q,
  output logic              remap_q,
  output logic              illegal_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_q <= 1'b0;
      fwd_write_q <= 1'b0;
      fwd_type_q  <= '0;
      fwd_addr_q  <= '0;
      rd_done_q   <= 1'b0;
      wr_done_q   <= 1'b0;
      done_addr_q <= '0;
      drop_q      <= 1'b0;
      remap_q     <= 1'b0;
      illegal_q   <= 1'b0;
    end else begin
      fwd_valid_q <= fwd_valid_d;
      fwd_write_q <= fwd_write_d;
      fwd_type_q  <= fwd_type_d;
      fwd_addr_q  <= fwd_addr_d;
      rd_done_q   <= rd_done_d;
      wr_done_q   <= wr_done_d;
      done_addr_q <= done_addr_d;
      drop_q      <= drop_d;
      remap_q     <= remap_d;
      illegal_q   <= illegal_d;
    end
  end
endmodule

// File: rtl/mmio_hole_remap.sv
module mmio_hole_remap
  import mmio_hole_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 64'h0000_0000_E000_0000,
  parameter logic [ADDR_W-1:0] HOLE_END  = 64'h0000_0001_0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              remap_en_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              fwd_valid_o,
  output logic              fwd_write_o,
  output logic [1:0]        fwd_type_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic              rd_done_o,
  output logic              wr_done_o,
  output logic [ADDR_W-1:0] done_addr_o,
  output logic              drop_pulse_o,
  output logic              remap_pulse_o,
  output logic              illegal_o
);
  localparam logic [ADDR_W-1:0] HoleSize = HOLE_END - HOLE_BASE;

  region_e           region;
  logic [ADDR_W-1:0] shifted_addr;
  logic              legal, accept, in_hole;

  hole_region_decode #(
    .ADDR_W(ADDR_W), .HOLE_BASE(HOLE_BASE), .HOLE_END(HOLE_END)
  ) u_decode (
    .en_i    (remap_en_i),
    .addr_i  (req_addr_i),
    .region_o(region)
  );

  hole_addr_shift #(
    .ADDR_W(ADDR_W), .HOLE_SIZE(HoleSize)
  ) u_shift (
    .region_i(region),
    .addr_i  (req_addr_i),
    .addr_o  (shifted_addr)
  );

  // legality is decided before routing: illegal types never reach a path
  assign legal   = txn_is_legal(req_type_i);
  assign accept  = req_valid_i && legal;
  assign in_hole = (region == REG_HOLE);

  remap_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fwd_valid_d(accept && !in_hole),
    .fwd_write_d(req_write_i),
    .fwd_type_d (req_type_i),
    .fwd_addr_d (shifted_addr),
    .rd_done_d  (accept && in_hole && !req_write_i),
    .wr_done_d  (accept && in_hole && req_write_i),
    .done_addr_d(req_addr_i),
    .drop_d     (accept && in_hole),
    .remap_d    (accept && (region == REG_HIGH)),
    .illegal_d  (req_valid_i && !legal),
    .fwd_valid_q(fwd_valid_o),
    .fwd_write_q(fwd_write_o),
    .fwd_type_q (fwd_type_o),
    .fwd_addr_q (fwd_addr_o),
    .rd_done_q  (rd_done_o),
    .wr_done_q  (wr_done_o),
    .done_addr_q(done_addr_o),
    .drop_q     (drop_pulse_o),
    .remap_q    (remap_pulse_o),
    .illegal_q  (illegal_o)
  );
endmodule

// File: rtl/mmio_hole_remap_chk.sv
module mmio_hole_remap_chk #(
  parameter int unsigned       ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] HOLE_BASE = 64'h0000_0000_E000_0000,
  parameter logic [ADDR_W-1:0] HOLE_END  = 64'h0000_0001_0000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              remap_en_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              fwd_valid_o,
  input logic [ADDR_W-1:0] fwd_addr_o,
  input logic              rd_done_o,
  input logic              wr_done_o,
  input logic [ADDR_W-1:0] done_addr_o,
  input logic              drop_pulse_o,
  input logic              remap_pulse_o,
  input logic              illegal_o
);
  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd_valid_o, rd_done_o, wr_done_o, illegal_o}));

  a_r5_shift_amount: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_pulse_o |-> (fwd_valid_o && (fwd_addr_o == $past(req_addr_i) - (HOLE_END - HOLE_BASE))));

  a_r6_drop_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_pulse_o == (rd_done_o || wr_done_o));

  a_r3_done_orig_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_o || wr_done_o) |-> (done_addr_o == $past(req_addr_i)));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(fwd_valid_o || rd_done_o || wr_done_o || illegal_o || drop_pulse_o || remap_pulse_o));

  a_r8_disabled_no_events: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !remap_en_i |=> !(drop_pulse_o || remap_pulse_o));

  a_r2_low_unchanged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !remap_pulse_o) |-> (fwd_addr_o == $past(req_addr_i)));
endmodule

bind mmio_hole_remap mmio_hole_remap_chk #(
  .ADDR_W(ADDR_W), .HOLE_BASE(HOLE_BASE), .HOLE_END(HOLE_END)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .remap_en_i   (remap_en_i),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .fwd_valid_o  (fwd_valid_o),
  .fwd_addr_o   (fwd_addr_o),
  .rd_done_o    (rd_done_o),
  .wr_done_o    (wr_done_o),
  .done_addr_o  (done_addr_o),
  .drop_pulse_o (drop_pulse_o),
  .remap_pulse_o(remap_pulse_o),
  .illegal_o    (illegal_o)
);

// File: tb/mmio_hole_remap_tb_top.sv
module mmio_hole_remap_tb_top;
  localparam logic [63:0] HB = 64'h0000_0000_E000_0000;
  localparam logic [63:0] HE = 64'h0000_0001_0000_0000;
  localparam logic [63:0] HS = 64'h0000_0000_2000_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        remap_en_i = 1'b0, req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_type_i = 2'd0;
  logic [63:0] req_addr_i = '0;
  logic        fwd_valid_o, fwd_write_o, rd_done_o, wr_done_o;
  logic        drop_pulse_o, remap_pulse_o, illegal_o;
  logic [1:0]  fwd_type_o;
  logic [63:0] fwd_addr_o, done_addr_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  mmio_hole_remap dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .remap_en_i(remap_en_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_type_i(req_type_i), .req_addr_i(req_addr_i),
    .fwd_valid_o(fwd_valid_o), .fwd_write_o(fwd_write_o),
    .fwd_type_o(fwd_type_o), .fwd_addr_o(fwd_addr_o),
    .rd_done_o(rd_done_o), .wr_done_o(wr_done_o), .done_addr_o(done_addr_o),
    .drop_pulse_o(drop_pulse_o), .remap_pulse_o(remap_pulse_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string pick_tag(logic en, logic v, logic w, logic [1:0] t, logic [63:0] a);
    if (!v) return "R10";
    if (t == 2'd1 || t == 2'd2) return "R7";
    if (!en) return "R8";
    if (t == 2'd3) return "R11";
    if (a >= HE) return "R5";
    if (a >= HB) return w ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic apply(input logic en, input logic v, input logic w,
                       input logic [1:0] t, input logic [63:0] a, input string tag_in);
    logic hole, high, legal, acc;
    logic [63:0] e_addr;
    string tag;
    remap_en_i = en; req_valid_i = v; req_write_i = w; req_type_i = t; req_addr_i = a;
    hole  = en && (a >= HB) && (a < HE);
    high  = en && (a >= HE);
    legal = (t != 2'd1) && (t != 2'd2);
    acc   = v && legal;
    e_addr = high ? a - HS : a;
    tag = (tag_in == "") ? pick_tag(en, v, w, t, a) : tag_in;
    @(negedge clk);
    chk(tag, "fwd_valid", 64'(fwd_valid_o), 64'(acc && !hole));
    if (acc && !hole) begin
      chk(tag, "fwd_addr", fwd_addr_o, e_addr);
      chk(tag, "fwd_write", 64'(fwd_write_o), 64'(w));
      chk(tag, "fwd_type", 64'(fwd_type_o), 64'(t));
    end
    chk(tag, "rd_done", 64'(rd_done_o), 64'(acc && hole && !w));
    chk(tag, "wr_done", 64'(wr_done_o), 64'(acc && hole && w));
    if (acc && hole) chk(tag, "done_addr", done_addr_o, a);
    chk("R6", "drop_pulse", 64'(drop_pulse_o), 64'(acc && hole));
    chk(tag, "remap_pulse", 64'(remap_pulse_o), 64'(acc && high));
    chk(tag, "illegal", 64'(illegal_o), 64'(v && !legal));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    remap_en_i = 1'b1; req_valid_i = 1'b1; req_addr_i = HB;  // R1: inputs active during reset
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset",
        64'({fwd_valid_o, rd_done_o, wr_done_o, drop_pulse_o, remap_pulse_o, illegal_o}), 64'd0);
    req_valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    apply(1, 1, 0, 2'd0, 64'h0000_0000_1234_5670, "R2");
    apply(1, 1, 1, 2'd0, 64'h0000_0000_0000_0000, "R2");
    apply(1, 1, 0, 2'd0, 64'h0000_0000_E800_0040, "R3");
    apply(1, 1, 1, 2'd0, 64'h0000_0000_F000_1000, "R4");
    apply(1, 1, 0, 2'd0, 64'h0000_0002_0000_0000, "R5");
    apply(1, 1, 0, 2'd0, 64'h0000_0000_DFFF_FFFF, "R9");
    apply(1, 1, 1, 2'd0, 64'h0000_0000_E000_0000, "R9");
    apply(1, 1, 0, 2'd0, 64'h0000_0000_FFFF_FFFF, "R9");
    apply(1, 1, 1, 2'd0, 64'h0000_0001_0000_0000, "R9");
    apply(1, 1, 0, 2'd1, 64'h0000_0000_E000_0000, "R7");
    apply(1, 1, 1, 2'd2, 64'h0000_0003_0000_0000, "R7");
    apply(0, 1, 0, 2'd2, 64'h0000_0000_0000_1000, "R7");
    apply(1, 1, 0, 2'd3, 64'h0000_0000_F000_0000, "R11");
    apply(1, 1, 1, 2'd3, 64'h0000_0001_4000_0000, "R11");
    apply(0, 1, 0, 2'd0, 64'h0000_0000_E000_0000, "R8");
    apply(0, 1, 1, 2'd0, 64'h0000_0001_0000_0000, "R8");
    apply(1, 0, 0, 2'd0, 64'h0000_0000_E000_0000, "R10");
    apply(1, 1, 1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    apply(1, 0, 1, 2'd0, 64'h0000_0001_0000_0000, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      logic [1:0] t;
      case ($urandom % 5)
        0: a = {32'd0, $urandom} % HB;
        1: a = HB + 64'($urandom % 32'h2000_0000);
        2: a = HE + 64'($urandom % 32'h100);
        3: a = HB - 64'($urandom % 32'h100) - 64'd1;
        default: a = {$urandom, $urandom} | HE;
      endcase
      t = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      apply(($urandom % 6) != 0, ($urandom % 5) != 0, 1'($urandom), t, a, "");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule